// File: doc/BRIEF.md
# I/O Port Region Decoder

This block turns the low byte of an 8-bit CPU's I/O address into active-low chip selects. The lower half of the port space, 00 to 7F, is reserved for on-board peripherals. It is cut into eight windows of sixteen ports each, and each window has its own select line. A display card and a keypad hang off the higher windows. The upper half, 80 to FF, raises no select, so expansion cards can decode it freely.

Some systems need more I/O. For them, a parameter switches on a second decoder. This decoder breaks the windows 10-1F and 20-2F into 32 single-port selects. The decode is purely combinational. A select goes low only during a genuine port access: the I/O request strobe must be low while the opcode-fetch strobe stays high. Because of this, an interrupt-acknowledge cycle, which pulls both strobes low, never looks like a port access.

Top module: `iodec_port_regions`

## Requirements
- R1: With `iorq_n` low and `m1_n` high, an address below 0x80 drives `region_sel_n[addr[6:4]]` low.
- R2: No more than one bit of `region_sel_n` is low at any time.
- R3: Every address from 0x80 to 0xFF leaves all of `region_sel_n` and `port_sel_n` high.
- R4: While `iorq_n` is high, every select output is high.
- R5: While `m1_n` is low, every select output is high, whatever `iorq_n` is. This keeps interrupt acknowledge from decoding as a port access.
- R6: With `FINE_ENABLE`=1 and a qualified access, `port_sel_n[i]` is low exactly when the address equals 0x10+i, for i from 0 to 31. Index 0 is port 0x10 and index 31 is port 0x2F. All other bits stay high.
- R7: Whenever a bit of `port_sel_n` is low, the region select of its window (index 1 for bits 0-15, index 2 for bits 16-31) is also low.
- R8: With `FINE_ENABLE`=0, all 32 bits of `port_sel_n` stay high for every input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| io_addr | input | 8 | Low byte of the I/O address |
| iorq_n | input | 1 | I/O request strobe, active low |
| m1_n | input | 1 | Opcode-fetch / interrupt-acknowledge strobe, active low |
| region_sel_n | output | 8 | Sixteen-port window selects for 00-7F, active low |
| port_sel_n | output | 32 | Single-port selects for 0x10-0x2F, active low |

## Verification
For addresses from 0x10 to 0x2F, a window select and a single-port select fall together. The bench provokes this by sweeping every address under all four strobe combinations. In the same evaluation it checks that exactly the right window bit and the right port bit are low, and that nothing else is. The same sweep drives interrupt acknowledge (both strobes low) across those addresses and expects both decoders to stay silent. A second instance, built with the single-port decoder disabled, shows its port outputs parked high while its window selects still match.

// File: rtl/iodec_pkg.sv
package iodec_pkg;

   // Default geometry of the reserved port space
   localparam int unsigned DEF_ADDR_W    = 8;  // I/O address bits decoded
   localparam int unsigned DEF_LOC_W     = 4;  // bits selecting a port inside a window
   localparam int unsigned DEF_RGN_W     = 3;  // bits selecting a window
   localparam int unsigned DEF_FINE_FRST = 1;  // first window split into single ports
   localparam int unsigned DEF_FINE_CNT  = 2;  // number of windows split

   // Qualification of a bus cycle as a port access
   typedef enum logic [1:0] {
      CYC_IDLE     = 2'b00,
      CYC_PORT     = 2'b01,
      CYC_INTACK   = 2'b10,
      CYC_FETCH    = 2'b11
   } io_cycle_e;

   function automatic io_cycle_e classify(input logic iorq_n, input logic m1_n);
      if (!iorq_n && m1_n)       return CYC_PORT;
      else if (!iorq_n && !m1_n) return CYC_INTACK;
      else if (!m1_n)            return CYC_FETCH;
      else                       return CYC_IDLE;
   endfunction

endpackage

// File: rtl/iodec_qualify.sv
module iodec_qualify
   import iodec_pkg::*;
(
   input  logic iorq_n,
   input  logic m1_n,
   output logic access_ok
);
   io_cycle_e cyc;

   always_comb begin
      cyc       = classify(iorq_n, m1_n);
      access_ok = (cyc == CYC_PORT);
   end
endmodule

// File: rtl/iodec_onehot_n.sv
module iodec_onehot_n #(
   parameter int unsigned IN_W = 3
) (
   input  logic                 en,
   input  logic [IN_W-1:0]      code,
   output logic [2**IN_W-1:0]   sel_n
);
   localparam int unsigned OUT_N = 2**IN_W;

   if (IN_W < 1 || IN_W > 8) begin : g_bad_w
      $error("iodec_onehot_n: IN_W out of range");
   end

   for (genvar i = 0; i < OUT_N; i++) begin : g_line
      localparam logic [IN_W-1:0] MATCH = IN_W'(i);
      assign sel_n[i] = ~(en && (code == MATCH));
   end
endmodule

// File: rtl/iodec_fine_bank.sv
module iodec_fine_bank #(
   parameter int unsigned HI_W  = 4,
   parameter int unsigned LOC_W = 4,
   parameter int unsigned FIRST = 1,
   parameter int unsigned COUNT = 2
) (
   input  logic                          access_ok,
   input  logic [HI_W-1:0]               hi,
   input  logic [LOC_W-1:0]              lo,
   output logic [COUNT*(2**LOC_W)-1:0]   sel_n
);
   localparam int unsigned PER_WIN = 2**LOC_W;

   if (COUNT < 1) begin : g_bad_cnt
      $error("iodec_fine_bank: COUNT must be at least one");
   end
   if (FIRST + COUNT > 2**HI_W) begin : g_bad_span
      $error("iodec_fine_bank: windows exceed the address field");
   end

   for (genvar g = 0; g < COUNT; g++) begin : g_win
      localparam logic [HI_W-1:0] WIN = HI_W'(FIRST + g);
      logic win_en;
      assign win_en = access_ok && (hi == WIN);

      iodec_onehot_n #(.IN_W(LOC_W)) u_dec (
         .en    (win_en),
         .code  (lo),
         .sel_n (sel_n[g*PER_WIN +: PER_WIN])
      );
   end
endmodule

// File: rtl/iodec_port_regions.sv
module iodec_port_regions
   import iodec_pkg::*;
#(
   parameter int unsigned ADDR_W      = DEF_ADDR_W,
   parameter int unsigned LOC_W       = DEF_LOC_W,
   parameter int unsigned RGN_W       = DEF_RGN_W,
   parameter bit          FINE_ENABLE = 1'b1,
   parameter int unsigned FINE_FIRST  = DEF_FINE_FRST,
   parameter int unsigned FINE_COUNT  = DEF_FINE_CNT
) (
   input  logic [ADDR_W-1:0]                  io_addr,
   input  logic                               iorq_n,
   input  logic                               m1_n,
   output logic [2**RGN_W-1:0]                region_sel_n,
   output logic [FINE_COUNT*(2**LOC_W)-1:0]   port_sel_n
);
   localparam int unsigned INT_W  = RGN_W + LOC_W;        // reserved space width
   localparam int unsigned HI_W   = ADDR_W - LOC_W;       // window index incl. upper bits
   localparam int unsigned FINE_W = FINE_COUNT * (2**LOC_W);

   // Elaboration-time parameter checks
   if (ADDR_W < INT_W) begin : g_bad_addr
      $error("iodec_port_regions: ADDR_W smaller than reserved space");
   end
   if (FINE_FIRST + FINE_COUNT > 2**RGN_W) begin : g_bad_fine
      $error("iodec_port_regions: single-port windows exceed region count");
   end

   logic access_ok;
   logic in_reserved;
   logic rgn_en;

   iodec_qualify u_qual (
      .iorq_n    (iorq_n),
      .m1_n      (m1_n),
      .access_ok (access_ok)
   );

   // Reserved space is the part where every bit above it is zero
   if (ADDR_W > INT_W) begin : g_upper
      assign in_reserved = (io_addr[ADDR_W-1:INT_W] == '0);
   end else begin : g_no_upper
      assign in_reserved = 1'b1;
   end

   assign rgn_en = access_ok && in_reserved;

   iodec_onehot_n #(.IN_W(RGN_W)) u_rgn (
      .en    (rgn_en),
      .code  (io_addr[INT_W-1:LOC_W]),
      .sel_n (region_sel_n)
   );

   if (FINE_ENABLE) begin : g_fine
      iodec_fine_bank #(
         .HI_W  (HI_W),
         .LOC_W (LOC_W),
         .FIRST (FINE_FIRST),
         .COUNT (FINE_COUNT)
      ) u_fine (
         .access_ok (access_ok),
         .hi        (io_addr[ADDR_W-1:LOC_W]),
         .lo        (io_addr[LOC_W-1:0]),
         .sel_n     (port_sel_n)
      );
   end else begin : g_fine_off
      assign port_sel_n = {FINE_W{1'b1}};
   end
endmodule

// File: rtl/iodec_port_regions_chk.sv
module iodec_port_regions_chk #(
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned LOC_W       = 4,
   parameter int unsigned RGN_W       = 3,
   parameter bit          FINE_ENABLE = 1'b1,
   parameter int unsigned FINE_FIRST  = 1,
   parameter int unsigned FINE_COUNT  = 2
) (
   input logic [ADDR_W-1:0]                  io_addr,
   input logic                               iorq_n,
   input logic                               m1_n,
   input logic [2**RGN_W-1:0]                region_sel_n,
   input logic [FINE_COUNT*(2**LOC_W)-1:0]   port_sel_n
);
   localparam int unsigned PER_WIN = 2**LOC_W;
   localparam int unsigned INT_W   = RGN_W + LOC_W;

   always_comb begin
      p_one_region_r2: assert ($onehot0(~region_sel_n))
         else $error("R2: several windows selected");
      p_upper_free_r3: assert (!(io_addr >= ADDR_W'(2**INT_W)) ||
                               (&region_sel_n && &port_sel_n))
         else $error("R3: select in free space");
      p_idle_r4: assert (!iorq_n || (&region_sel_n && &port_sel_n) || m1_n)
         else $error("R4: select without request");
      p_iorq_high_r4: assert (!iorq_n || (&region_sel_n && &port_sel_n))
         else $error("R4: select with strobe idle");
      p_intack_r5: assert (m1_n || (&region_sel_n && &port_sel_n))
         else $error("R5: select during M1");
      p_fine_one_r6: assert ($onehot0(~port_sel_n))
         else $error("R6: several ports selected");
      p_fine_off_r8: assert (FINE_ENABLE || &port_sel_n)
         else $error("R8: disabled port select active");
   end

   for (genvar i = 0; i < FINE_COUNT * PER_WIN; i++) begin : g_nest
      always_comb begin
         p_nested_r7: assert (port_sel_n[i] || !region_sel_n[FINE_FIRST + i / PER_WIN])
            else $error("R7: port select outside its window");
      end
   end
endmodule

bind iodec_port_regions iodec_port_regions_chk #(
   .ADDR_W      (ADDR_W),
   .LOC_W       (LOC_W),
   .RGN_W       (RGN_W),
   .FINE_ENABLE (FINE_ENABLE),
   .FINE_FIRST  (FINE_FIRST),
   .FINE_COUNT  (FINE_COUNT)
) u_chk (
   .io_addr      (io_addr),
   .iorq_n       (iorq_n),
   .m1_n         (m1_n),
   .region_sel_n (region_sel_n),
   .port_sel_n   (port_sel_n)
);

// File: tb/iodec_port_regions_tb.sv
module iodec_port_regions_tb;
   logic clk = 1'b0;
   always #2 clk = ~clk;   // 250 MHz

   logic [7:0]  io_addr = 8'h00;
   logic        iorq_n  = 1'b1;
   logic        m1_n    = 1'b1;
   logic [7:0]  rgn_n,  rgn_off_n;
   logic [31:0] port_n, port_off_n;

   int vectors = 0;
   int fails   = 0;
   bit done    = 1'b0;

   iodec_port_regions u_dut (
      .io_addr(io_addr), .iorq_n(iorq_n), .m1_n(m1_n),
      .region_sel_n(rgn_n), .port_sel_n(port_n));

   iodec_port_regions #(.FINE_ENABLE(1'b0)) u_dut_off (
      .io_addr(io_addr), .iorq_n(iorq_n), .m1_n(m1_n),
      .region_sel_n(rgn_off_n), .port_sel_n(port_off_n));

   task automatic chk32(input string tag, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s addr=%02h iorq_n=%b m1_n=%b act=%h exp=%h",
                  tag, io_addr, iorq_n, m1_n, act, exp);
      end
   endtask

   task automatic apply(input int a, input bit rq_n, input bit f_n);
      logic [7:0]  er;
      logic [31:0] ep;
      bit ok;
      string rt;
      @(posedge clk);
      io_addr = 8'(a);
      iorq_n  = rq_n;
      m1_n    = f_n;
      @(negedge clk);
      ok = !rq_n && f_n;
      er = 8'hFF;
      ep = 32'hFFFF_FFFF;
      if (ok && a < 128) er[a / 16] = 1'b0;
      if (ok && a >= 16 && a < 48) ep[a - 16] = 1'b0;
      if (rq_n)         rt = "R4";
      else if (!f_n)    rt = "R5";
      else if (a >= 128) rt = "R3";
      else              rt = "R1";
      chk32({rt, " window"}, {24'hFF_FFFF, rgn_n}, {24'hFF_FFFF, er});
      chk32({rt == "R1" ? "R6" : rt, " port"}, port_n, ep);
      chk32("R8 disabled ports", port_off_n, 32'hFFFF_FFFF);
      chk32({rt, " window disabled-variant"}, {24'hFF_FFFF, rgn_off_n}, {24'hFF_FFFF, er});
      // R2: at most one window low
      chk32("R2 onehot", 32'($countones(~rgn_n) <= 1), 32'd1);
      // R7: port select implies its window select
      if (port_n != 32'hFFFF_FFFF) begin
         int idx = 0;
         for (int k = 0; k < 32; k++) if (!port_n[k]) idx = k;
         chk32("R7 nesting", {31'd0, rgn_n[1 + idx / 16]}, 32'd0);
      end
   endtask

   initial begin
      // Reset/idle state: strobes inactive (R4)
      @(negedge clk);
      chk32("R4 idle windows", {24'hFF_FFFF, rgn_n}, 32'hFFFF_FFFF);
      chk32("R4 idle ports", port_n, 32'hFFFF_FFFF);
      for (int s = 0; s < 4; s++) begin
         for (int a = 0; a < 256; a++) begin
            apply(a, s[0], s[1]);
         end
      end
      // Boundary addresses under a port access
      apply(8'h0F, 1'b0, 1'b1);
      apply(8'h10, 1'b0, 1'b1);
      apply(8'h2F, 1'b0, 1'b1);
      apply(8'h30, 1'b0, 1'b1);
      apply(8'h7F, 1'b0, 1'b1);
      apply(8'h80, 1'b0, 1'b1);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog act=running exp=finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end
endmodule